// File: doc/BRIEF.md
# Frame-Strobe Clocked Watchdog

This block supervises the firmware of a telephony controller. It counts falling edges of the voice frame strobe. When the host fails to prove it is alive within a programmable number of frames, it raises an output that can reset an external microcontroller. The host proves it is alive by writing a fixed 5-bit service key to one register address. Each correct write starts a fresh interval. The count moves only while the frame strobe is running. If the strobe stops, supervision pauses and no timeout can happen.

When an interval ends with no correct service, the output goes high. It then changes level at the end of every later interval, so the controller gets repeated reset pulses until the firmware writes the key again. A correct write pulls the output low at once and restarts the interval from zero. The power-on reset input holds the output high while it is asserted. Releasing it starts the first interval with the output low.

The design runs on one system clock. The frame strobe is resynchronised and edge-detected in that clock domain. At the default 4096 frames, an 8 kHz strobe gives a timeout of about half a second.

Top module: `frame_watchdog`

## Requirements
- R1: While `por_i` is high, `wd_o` is high on every clock and stays high whatever the other inputs do.
- R2: On the first clock edge with `por_i` low, `wd_o` goes low and a new interval starts from a count of zero.
- R3: The interval advances only on falling edges of `strobe_i`. Rising edges, and a strobe held at a steady level for any time, never cause a timeout.
- R4: If `TERM_COUNT` falling edges of the strobe pass after the start of an interval with no valid service, `wd_o` goes from low to high on the last of them. After `TERM_COUNT-1` edges it is still low.
- R5: A valid service is a write (`wr_en_i` high) to address 0x11 whose data bits 4..0 equal 0b01010. Data bits 7..5 are ignored. A valid service restarts the interval from zero.
- R6: A write to address 0x11 whose bits 4..0 differ from 0b01010 does not restart the interval and does not change `wd_o`.
- R7: A write to any address other than 0x11 has no effect on `wd_o` or on the interval, whatever its data.
- R8: After a timeout, `wd_o` inverts at the end of every later interval of `TERM_COUNT` falling edges for as long as no valid service arrives.
- R9: A valid service while `wd_o` is high drives `wd_o` low on the next clock edge. The following timeout comes exactly `TERM_COUNT` falling edges later.
- R10: When a valid service arrives on the same clock as the falling edge that ends an interval, the service wins. `wd_o` stays low and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| strobe_i | input | 1 | Frame strobe, asynchronous to clk_i; its falling edges advance the interval |
| wr_en_i | input | 1 | Register write strobe, one clock per write |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| wd_o | output | 1 | Watchdog output to the controller reset, registered |

## Verification
A wrong count or a lost service shows at `wd_o` only at the end of an interval. A timeout that comes one frame early or late is therefore caught by checking the output at `TERM_COUNT-1` and `TERM_COUNT` edges after each restart. A state bit stuck in the failed mode shows as a missing or extra toggle within one interval after a service. A bad address or key decode shows as a timeout one interval too early, or as no timeout at all. A lost priority between service and expiry shows as `wd_o` high one clock after a write that lands on the terminal frame edge.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic {
    FWD_ARMED   = 1'b0,
    FWD_TRIPPED = 1'b1
  } fwd_mode_e;

endpackage

// File: rtl/fwd_strobe_edge.sv
module fwd_strobe_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic strobe_i,
  output logic fall_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) sync_q[0] <= 1'b0;
    else       sync_q[0] <= strobe_i;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i) begin
      if (rst_i) sync_q[g] <= 1'b0;
      else       sync_q[g] <= sync_q[g-1];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) last_q <= 1'b0;
    else       last_q <= sync_q[SYNC_STAGES-1];
  end

  assign fall_o = last_q & ~sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/fwd_service_decode.sv
module fwd_service_decode #(
  parameter int              ADDR_W   = 8,
  parameter int              DATA_W   = 8,
  parameter int              KEY_W    = 5,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 8'h11,
  parameter logic [KEY_W-1:0]  SVC_KEY  = 5'b01010
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              svc_o
);

  localparam logic [DATA_W-1:0] KEY_MASK = DATA_W'((1 << KEY_W) - 1);
  localparam logic [DATA_W-1:0] KEY_FULL = DATA_W'(SVC_KEY);

  logic addr_hit;
  logic key_hit;

  always_comb begin
    addr_hit = (wr_addr_i == SVC_ADDR);
    key_hit  = (((wr_data_i ^ KEY_FULL) & KEY_MASK) == '0);
    svc_o    = wr_en_i & addr_hit & key_hit;
  end

endmodule

// File: rtl/fwd_interval.sv
module fwd_interval #(
  parameter int TERM_COUNT = 4096,
  parameter int CNT_W      = $clog2(TERM_COUNT)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  logic             restart_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(TERM_COUNT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || restart_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire_o = tick_i & ~restart_i & (cnt_q == LAST);
  assign cnt_o    = cnt_q;

endmodule

// File: rtl/frame_watchdog.sv
module frame_watchdog
  import fwd_pkg::*;
#(
  parameter int              TERM_COUNT  = 4096,
  parameter int              SYNC_STAGES = 2,
  parameter int              ADDR_W      = 8,
  parameter int              DATA_W      = 8,
  parameter int              KEY_W       = 5,
  parameter logic [ADDR_W-1:0] SVC_ADDR  = 8'h11,
  parameter logic [KEY_W-1:0]  SVC_KEY   = 5'b01010
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              strobe_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wd_o
);

  localparam int CNT_W = $clog2(TERM_COUNT);

  logic             tick_w;
  logic             svc_w;
  logic             expire_w;
  logic [CNT_W-1:0] cnt_w;
  fwd_mode_e        mode_q;
  logic             wd_q;

  fwd_strobe_edge #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk_i   (clk_i),
    .rst_i   (por_i),
    .strobe_i(strobe_i),
    .fall_o  (tick_w)
  );

  fwd_service_decode #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .KEY_W   (KEY_W),
    .SVC_ADDR(SVC_ADDR),
    .SVC_KEY (SVC_KEY)
  ) u_dec (
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .svc_o    (svc_w)
  );

  fwd_interval #(
    .TERM_COUNT(TERM_COUNT),
    .CNT_W     (CNT_W)
  ) u_int (
    .clk_i    (clk_i),
    .rst_i    (por_i),
    .tick_i   (tick_w),
    .restart_i(svc_w),
    .expire_o (expire_w),
    .cnt_o    (cnt_w)
  );

  always_ff @(posedge clk_i) begin
    if (por_i) begin
      mode_q <= FWD_ARMED;
      wd_q   <= 1'b1;
    end else if (svc_w) begin
      mode_q <= FWD_ARMED;
      wd_q   <= 1'b0;
    end else if (expire_w) begin
      mode_q <= FWD_TRIPPED;
      wd_q   <= (mode_q == FWD_ARMED) ? 1'b1 : ~wd_q;
    end else if (mode_q == FWD_ARMED) begin
      wd_q   <= 1'b0;
    end
  end

  assign wd_o = wd_q;

endmodule

// File: rtl/frame_watchdog_chk.sv
module frame_watchdog_chk #(
  parameter int              TERM_COUNT = 4096,
  parameter int              ADDR_W     = 8,
  parameter int              DATA_W     = 8,
  parameter int              CNT_W      = $clog2(TERM_COUNT),
  parameter logic [ADDR_W-1:0] SVC_ADDR = 8'h11
) (
  input logic              clk_i,
  input logic              por_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              wd_o,
  input logic              tick,
  input logic [CNT_W-1:0]  cnt
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(TERM_COUNT - 1);

  logic svc_seen;
  assign svc_seen = wr_en_i && (wr_addr_i == SVC_ADDR) && (wr_data_i[4:0] == 5'b01010);

  // R1
  p_por_high_r1: assert property (@(posedge clk_i) por_i |=> wd_o);

  // R2
  p_release_low_r2: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(por_i) |=> !wd_o);

  // R3
  p_quiet_hold_r3: assert property (@(posedge clk_i) disable iff (por_i)
    (!tick && !svc_seen && !$past(por_i)) |=> $stable(wd_o));

  // R4
  p_cnt_range_r4: assert property (@(posedge clk_i) disable iff (por_i) cnt <= LAST);

  // R4
  p_timeout_high_r4: assert property (@(posedge clk_i) disable iff (por_i)
    (tick && cnt == LAST && !svc_seen && !wd_o) |=> wd_o);

  // R8
  p_toggle_r8: assert property (@(posedge clk_i) disable iff (por_i)
    (tick && cnt == LAST && !svc_seen && !$past(por_i)) |=> (wd_o != $past(wd_o)));

  // R9 and R10
  p_service_low_r9: assert property (@(posedge clk_i) disable iff (por_i)
    svc_seen |=> (!wd_o && cnt == '0));

endmodule

bind frame_watchdog frame_watchdog_chk #(
  .TERM_COUNT(TERM_COUNT),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .CNT_W     (CNT_W),
  .SVC_ADDR  (SVC_ADDR)
) u_chk (
  .clk_i    (clk_i),
  .por_i    (por_i),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .wd_o     (wd_o),
  .tick     (tick_w),
  .cnt      (cnt_w)
);

// File: tb/sim_frame_watchdog.sv
`timescale 1ns/1ps
module sim_frame_watchdog;

  localparam int TERM = 8;

  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       strobe = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic       wd;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  frame_watchdog #(.TERM_COUNT(TERM)) u0 (
    .clk_i    (clk),
    .por_i    (por),
    .strobe_i (strobe),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .wd_o     (wd)
  );

  task automatic chk(input string tag, input logic exp);
    checks++;
    if (wd !== exp) begin
      failures++;
      $display("FAIL %s: wd actual=%b expected=%b at %0t", tag, wd, exp, $time);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      strobe = 1'b1;
      repeat (4) @(negedge clk);
      strobe = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 8'h00; wr_data = 8'h00;
  endtask

  task automatic t_reset;
    por = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 held in reset", 1'b1);
    pulses(2);
    wr(8'h11, 8'h0A);
    chk("R1 service during reset", 1'b1);
    por = 1'b0;
    @(negedge clk);
    chk("R2 release", 1'b0);
  endtask

  task automatic t_timeout;
    pulses(TERM - 1);
    chk("R4 one edge short", 1'b0);
    pulses(1);
    chk("R4 terminal edge", 1'b1);
  endtask

  task automatic t_toggle;
    pulses(TERM - 1);
    chk("R8 mid interval", 1'b1);
    pulses(1);
    chk("R8 first toggle", 1'b0);
    pulses(TERM);
    chk("R8 second toggle", 1'b1);
  endtask

  task automatic t_service_in_fail;
    wr(8'h11, 8'h0A);
    chk("R9 low at once", 1'b0);
    pulses(TERM - 1);
    chk("R9 restarted from zero", 1'b0);
    pulses(1);
    chk("R9 next timeout", 1'b1);
  endtask

  task automatic t_service_normal;
    wr(8'h11, 8'h0A);
    pulses(TERM - 2);
    wr(8'h11, 8'hEA);
    chk("R5 upper bits ignored", 1'b0);
    pulses(TERM - 1);
    chk("R5 restart held", 1'b0);
    pulses(1);
    chk("R5 timeout after restart", 1'b1);
  endtask

  task automatic t_wrong_key;
    wr(8'h11, 8'h0B);
    chk("R6 wrong key in fail", 1'b1);
    wr(8'h11, 8'h0A);
    pulses(3);
    wr(8'h11, 8'h0B);
    chk("R6 wrong key no change", 1'b0);
    pulses(TERM - 4);
    chk("R6 before expiry", 1'b0);
    pulses(1);
    chk("R6 no restart", 1'b1);
  endtask

  task automatic t_other_addr;
    wr(8'h11, 8'h0A);
    pulses(3);
    wr(8'h12, 8'h0A);
    chk("R7 other address", 1'b0);
    wr(8'h10, 8'h0A);
    pulses(TERM - 4);
    chk("R7 before expiry", 1'b0);
    pulses(1);
    chk("R7 no restart", 1'b1);
  endtask

  task automatic t_frozen;
    wr(8'h11, 8'h0A);
    pulses(TERM - 1);
    strobe = 1'b1;
    repeat (200) @(negedge clk);
    chk("R3 strobe stuck high", 1'b0);
    strobe = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3 falling edge counted", 1'b1);
    wr(8'h11, 8'h0A);
    pulses(TERM - 1);
    repeat (200) @(negedge clk);
    chk("R3 strobe stuck low", 1'b0);
  endtask

  task automatic t_coincide;
    wr(8'h11, 8'h0A);
    pulses(TERM - 1);
    strobe = 1'b1;
    repeat (4) @(negedge clk);
    strobe = 1'b0;
    repeat (2) @(negedge clk);
    wr(8'h11, 8'h0A);
    chk("R10 service wins", 1'b0);
    repeat (2) @(negedge clk);
    pulses(TERM - 1);
    chk("R10 count restarted", 1'b0);
    pulses(1);
    chk("R10 next timeout", 1'b1);
  endtask

  task automatic t_reset_in_fail;
    por = 1'b1;
    @(negedge clk);
    chk("R1 reset from fail", 1'b1);
    por = 1'b0;
    @(negedge clk);
    chk("R2 release from fail", 1'b0);
    pulses(TERM);
    chk("R2 fresh interval", 1'b1);
  endtask

  initial begin
    t_reset();
    t_timeout();
    t_toggle();
    t_service_in_fail();
    t_service_normal();
    t_wrong_key();
    t_other_addr();
    t_frozen();
    t_coincide();
    t_reset_in_fail();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL timeout: run actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule